// File: doc/BRIEF.md
# External Memory Strobe Sequencer

This block times the control strobes of a single external memory access. When it is idle and a request arrives, it latches the configuration word of the selected bank and the access direction. It then steps a phase counter through the access. Each phase is one cycle of `clk_i`, which runs at twice the memory bus rate, so strobe edges can land on either half of a bus cycle.

Each strobe edge is programmed on its own:
- Chip enable, output enable, write strobe and write data drive are each asserted a programmed number of phases after the access starts.
- Chip enable and the write strobe are released a programmed number of phases before the access ends.
- Output enable and the data drive stay on until the access ends.

After the last phase the block keeps the bus quiet for a release gap counted in whole bus cycles (two phases each), and only then accepts the next request. A per-bank wait enable lets `wait_i` freeze the counter just before the first strobe release, so a slow device can stretch the access.

Top module: `emi_strobe_seq`

## Requirements
- R1: Each bank word in `cfg_i` is CFG_W=30 bits; bank b sits at bits [30b+29:30b]. Within a word the fields are:

  | Field | Bits | Meaning |
  |---|---|---|
  | wait_en | [0] | honour `wait_i` for this bank |
  | drv | [3:1] | data drive delay, phases |
  | dur | [7:4] | access duration, phases |
  | ce_on | [11:8] | chip enable assert delay, phases |
  | ce_off | [15:12] | chip enable release before end, phases |
  | oe_on | [19:16] | output enable assert delay, phases |
  | wb_on | [23:20] | write strobe assert delay, phases |
  | wb_off | [27:24] | write strobe release before end, phases |
  | rel | [29:28] | release gap, bus cycles |

  A request sampled while idle takes effect on the next clock. That cycle is phase 0 and `busy_o` is high from it on.
- R2: An access lasts L phases, where L = dur, or 1 when dur is 0. `done_o` is high for exactly one clock, during phase L-1.
- R3: `ce_no` is low in every phase p with ce_on <= p < L-ce_off. When ce_off >= L, it is low in no phase.
- R4: `oe_no` is low only on reads (`we_i`=0), in phases with oe_on <= p < L. It is never low together with `wb_no`.
- R5: `wb_no` is low only on writes, in phases with wb_on <= p < L-wb_off.
- R6: `dout_en_o` is high only on writes, in phases with drv <= p < L.
- R7: A strobe whose assert delay is not below L does not assert during that access.
- R8: After phase L-1, `busy_o` stays high with all strobes inactive for 2*rel clocks. The block is idle on the clock after that.
- R9: Let E be the earliest release point: L-ce_off on reads, or the smaller of L-ce_off and L-wb_off on writes, each floored at 0. Let H = max(E-1, 0). With wait_en set, each clock in phase H with `wait_i` high repeats phase H with all outputs unchanged and `done_o` low.
- R10: With wait_en clear, `wait_i` has no effect on the sequence.
- R11: While reset is low, and whenever the block is idle, all strobes are inactive and `busy_o` and `done_o` are low.
- R12: A request that arrives while `busy_o` is high is ignored and does not start an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | phase clock, twice the bus rate |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_i | input | 1 | access request, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| bank_i | input | 2 | bank select |
| cfg_i | input | 120 | configuration words of all banks |
| wait_i | input | 1 | wait from the external device |
| ce_no | output | 1 | chip enable, active low |
| oe_no | output | 1 | output enable, active low |
| wb_no | output | 1 | write strobe, active low |
| dout_en_o | output | 1 | data bus output enable |
| done_o | output | 1 | one-clock pulse in the last phase |
| busy_o | output | 1 | access or release gap in progress |

## Verification
The hardest case to reach is a wait stall at the hold phase. The hold phase moves with duration, chip enable release and, on writes, write strobe release, so a fixed wait pattern almost never lands on it. The bench therefore computes the hold phase for every configuration it sweeps and raises `wait_i` only at that phase, for two clocks. This covers holds at phase 0, in mid-access and in the final phase. A parallel set of sweeps keeps `wait_i` high through whole accesses of banks with wait disabled, and injects requests during release gaps.

// File: rtl/emi_seq_pkg.sv
package emi_seq_pkg;
  localparam int PH_W  = 4;
  localparam int DRV_W = 3;
  localparam int REL_W = 2;

  typedef struct packed {
    logic [REL_W-1:0] rel;
    logic [PH_W-1:0]  wb_off;
    logic [PH_W-1:0]  wb_on;
    logic [PH_W-1:0]  oe_on;
    logic [PH_W-1:0]  ce_off;
    logic [PH_W-1:0]  ce_on;
    logic [PH_W-1:0]  dur;
    logic [DRV_W-1:0] drv;
    logic             wait_en;
  } bank_cfg_t;

  localparam int CFG_W = $bits(bank_cfg_t);

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_REL} seq_st_e;
endpackage

// File: rtl/strobe_window.sv
module strobe_window #(
  parameter int W = 5
) (
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] stop_i,
  output logic         on_o
);
  assign on_o = (pos_i >= start_i) && (pos_i < stop_i);
endmodule

// File: rtl/seq_limits.sv
module seq_limits
  import emi_seq_pkg::*;
#(
  parameter int PW = PH_W + 1
) (
  input  bank_cfg_t     cfg_i,
  input  logic          wr_i,
  output logic [PW-1:0] len_o,
  output logic [PW-1:0] ce_stop_o,
  output logic [PW-1:0] wb_stop_o,
  output logic [PW-1:0] hold_o
);
  logic [PW-1:0] ce_off_w, wb_off_w, first_w;

  assign ce_off_w  = PW'(cfg_i.ce_off);
  assign wb_off_w  = PW'(cfg_i.wb_off);
  assign len_o     = (cfg_i.dur == '0) ? PW'(1) : PW'(cfg_i.dur);
  assign ce_stop_o = (len_o > ce_off_w) ? len_o - ce_off_w : '0;
  assign wb_stop_o = (len_o > wb_off_w) ? len_o - wb_off_w : '0;

  // counter freezes one phase before the earliest programmed release
  always_comb begin
    first_w = ce_stop_o;
    if (wr_i && (wb_stop_o < first_w)) first_w = wb_stop_o;
  end
  assign hold_o = (first_w == '0) ? '0 : first_w - PW'(1);
endmodule

// File: rtl/emi_strobe_seq.sv
module emi_strobe_seq
  import emi_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int PW     = PH_W + 1,
  localparam int RC_W   = REL_W + 1,
  localparam int NWIN   = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic [NUM_BANKS*CFG_W-1:0] cfg_i,
  input  logic                       wait_i,
  output logic                       ce_no,
  output logic                       oe_no,
  output logic                       wb_no,
  output logic                       dout_en_o,
  output logic                       done_o,
  output logic                       busy_o
);
  seq_st_e       st_q;
  bank_cfg_t     cfg_q, sel_cfg;
  logic          wr_q;
  logic [PW-1:0] ph_q;
  logic [RC_W-1:0] rel_q;

  logic [PW-1:0] len_w, ce_stop_w, wb_stop_w, hold_w;
  logic [PW-1:0] win_start [NWIN];
  logic [PW-1:0] win_stop  [NWIN];
  logic [NWIN-1:0] win_on;
  logic          acc, stall, last;

  assign sel_cfg = bank_cfg_t'(cfg_i[bank_i*CFG_W +: CFG_W]);

  seq_limits #(.PW(PW)) u_limits (
    .cfg_i    (cfg_q),
    .wr_i     (wr_q),
    .len_o    (len_w),
    .ce_stop_o(ce_stop_w),
    .wb_stop_o(wb_stop_w),
    .hold_o   (hold_w)
  );

  // window 0: chip enable, 1: output enable, 2: write strobe, 3: data drive
  assign win_start[0] = PW'(cfg_q.ce_on);
  assign win_stop[0]  = ce_stop_w;
  assign win_start[1] = PW'(cfg_q.oe_on);
  assign win_stop[1]  = len_w;
  assign win_start[2] = PW'(cfg_q.wb_on);
  assign win_stop[2]  = wb_stop_w;
  assign win_start[3] = PW'(cfg_q.drv);
  assign win_stop[3]  = len_w;

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    strobe_window #(.W(PW)) u_win (
      .pos_i  (ph_q),
      .start_i(win_start[gi]),
      .stop_i (win_stop[gi]),
      .on_o   (win_on[gi])
    );
  end

  assign acc   = (st_q == ST_ACC);
  assign stall = acc && cfg_q.wait_en && wait_i && (ph_q == hold_w);
  assign last  = (ph_q == len_w - PW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cfg_q <= '0;
      wr_q  <= 1'b0;
      ph_q  <= '0;
      rel_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          st_q  <= ST_ACC;
          cfg_q <= sel_cfg;
          wr_q  <= we_i;
          ph_q  <= '0;
        end
        ST_ACC: if (!stall) begin
          if (last) begin
            ph_q <= '0;
            if (cfg_q.rel == '0) st_q <= ST_IDLE;
            else begin
              st_q  <= ST_REL;
              rel_q <= {cfg_q.rel, 1'b0} - RC_W'(1);
            end
          end else begin
            ph_q <= ph_q + PW'(1);
          end
        end
        ST_REL: begin
          if (rel_q == '0) st_q <= ST_IDLE;
          else             rel_q <= rel_q - RC_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ce_no     = ~(acc && win_on[0]);
  assign oe_no     = ~(acc && !wr_q && win_on[1]);
  assign wb_no     = ~(acc && wr_q && win_on[2]);
  assign dout_en_o = acc && wr_q && win_on[3];
  assign done_o    = acc && last && !stall;
  assign busy_o    = (st_q != ST_IDLE);
endmodule

// File: rtl/emi_strobe_seq_chk.sv
module emi_strobe_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic ce_no,
  input logic oe_no,
  input logic wb_no,
  input logic dout_en_o,
  input logic done_o,
  input logic busy_o
);
  // R4
  oe_wb_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_no && !wb_no));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ce_no && oe_no && wb_no && !dout_en_o && !done_o));

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  post_done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (ce_no && oe_no && wb_no && !dout_en_o));

  // R1
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i) |=> busy_o);
endmodule

bind emi_strobe_seq emi_strobe_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .ce_no    (ce_no),
  .oe_no    (oe_no),
  .wb_no    (wb_no),
  .dout_en_o(dout_en_o),
  .done_o   (done_o),
  .busy_o   (busy_o)
);

// File: tb/emi_strobe_seq_tb.sv
module emi_strobe_seq_tb;
  localparam int NB = 4;
  localparam int CW = 30;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, wait_i = 1'b0;
  logic [1:0] bank_i = '0;
  logic [NB*CW-1:0] cfg_i = '0;
  logic ce_no, oe_no, wb_no, dout_en_o, done_o, busy_o;

  int checks = 0, errors = 0;
  bit wd_hit = 0;

  always #4 clk_i = ~clk_i;

  emi_strobe_seq #(.NUM_BANKS(NB)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .bank_i(bank_i), .cfg_i(cfg_i), .wait_i(wait_i),
    .ce_no(ce_no), .oe_no(oe_no), .wb_no(wb_no),
    .dout_en_o(dout_en_o), .done_o(done_o), .busy_o(busy_o)
  );

  function automatic logic [CW-1:0] mk_cfg(int wen, int drv, int dur, int con,
      int coff, int oon, int won, int woff, int rel);
    logic [CW-1:0] w;
    w = '0;
    w[0] = wen[0]; w[3:1] = drv[2:0]; w[7:4] = dur[3:0]; w[11:8] = con[3:0];
    w[15:12] = coff[3:0]; w[19:16] = oon[3:0]; w[23:20] = won[3:0];
    w[27:24] = woff[3:0]; w[29:28] = rel[1:0];
    return w;
  endfunction

  // {busy, done, ce_n, oe_n, wb_n, dout_en}
  task automatic chk(string tag, logic [5:0] exp);
    logic [5:0] act;
    act = {busy_o, done_o, ce_no, oe_no, wb_no, dout_en_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // one access; nstall = wait clocks at the hold phase, wait_hi = keep wait_i high
  task automatic run(int bank, bit wr, logic [CW-1:0] w, int nstall, bit wait_hi, string tag);
    int len, ce_stop, wb_stop, first, hold, rel, p, stl;
    bit wen, stall_now, dr;
    for (int b = 0; b < NB; b++) cfg_i[b*CW +: CW] = ~w;
    cfg_i[bank*CW +: CW] = w;
    len = (w[7:4] == 0) ? 1 : int'(w[7:4]);
    ce_stop = (len > int'(w[15:12])) ? len - int'(w[15:12]) : 0;
    wb_stop = (len > int'(w[27:24])) ? len - int'(w[27:24]) : 0;
    first = (wr && wb_stop < ce_stop) ? wb_stop : ce_stop;
    hold = (first == 0) ? 0 : first - 1;
    rel = int'(w[29:28]);
    wen = w[0];
    bank_i = bank[1:0]; we_i = wr; req_i = 1'b1;
    p = 0; stl = nstall;
    while (p < len) begin
      @(negedge clk_i);
      req_i = 1'b0;
      dr = wait_hi || (p == hold && stl > 0);
      wait_i = dr;
      stall_now = wen && dr && (p == hold);
      #1;
      // R1 R2 R3 R4 R5 R6 R7 R9 R10
      chk(tag, {1'b1, (p == len-1) && !stall_now,
                !(p >= int'(w[11:8]) && p < ce_stop),
                !(!wr && p >= int'(w[19:16]) && p < len),
                !(wr && p >= int'(w[23:20]) && p < wb_stop),
                wr && p >= int'(w[3:1]) && p < len});
      if (stall_now) stl--; else p++;
    end
    for (int r = 0; r < 2*rel; r++) begin
      @(negedge clk_i);
      wait_i = 1'b0;
      req_i = (r == 0); // R12: request during release gap
      #1;
      chk({tag, " R8 gap"}, 6'b101110);
    end
    @(negedge clk_i);
    req_i = 1'b0; wait_i = 1'b0;
    #1;
    chk({tag, " R8 R12 idle"}, 6'b001110);
  endtask

  initial begin
    #20000000;
    wd_hit = 1;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1 chk("R11 reset", 6'b001110);
    rst_ni = 1'b1;
    @(negedge clk_i); #1 chk("R11 idle", 6'b001110);
    for (int k = 0; k < 3 && !wd_hit; k++)
      for (int d = 0; d < 16 && !wd_hit; d++)
        for (int wr = 0; wr < 2; wr++) begin
          logic [CW-1:0] w;
          if (k == 2) // R7: assert delays at or past the duration
            w = mk_cfg(1, 7, d, d, 0, d + (d % 2), 15, 0, d % 4);
          else
            w = mk_cfg(k == 0 ? 1 : 0, d % 8, d, (d + k) % 5, (d * 3) % 4,
                       d % 7, (d + 1) % 4, d % 3, (d + k) % 4);
          run(d % NB, wr[0], w, 2, k == 1, k == 0 ? "R9 sweep" : (k == 1 ? "R10 sweep" : "R7 sweep"));
        end
    if (wd_hit) begin
      checks++; errors++;
      $display("FAIL watchdog: act=expired exp=complete");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule